// File: doc/BRIEF.md
# Power-good and overvoltage window monitor

This block watches a digitized feedback sample from a switching regulator. The feedback code is scaled so that the parameter `TARGET_CODE` is the regulation point. From each valid sample it keeps two hysteresis comparators. The first tracks whether the output is inside its good band. The second tracks an overvoltage window, which a control loop can use to stop switching.

The power-good comparator is time-qualified before it reaches the pin. A new good/not-good level must persist for 25 us, counted in clock cycles from a clock-frequency parameter, before the open-drain control changes. Any sample that undoes a pending change restarts that interval. The overvoltage flag is not filtered. All thresholds are integer codes computed at elaboration as target times per-mille value over 1000, so no division happens in hardware.

Top module: `pg_ov_monitor`

## Requirements
- R1: A valid sample at or above 95.0% of `TARGET_CODE` (code 1900 with defaults) sets `pg_raw` on the capturing edge. Code 1899 does not set it.
- R2: A valid sample below 92.5% of `TARGET_CODE` (below 1850) clears `pg_raw`. Samples from 1850 to 1899 leave `pg_raw` unchanged.
- R3: When `pg_raw` differs from the debounced level, that level takes the value of `pg_raw` exactly `DB_CYC` clock cycles after `pg_raw` changed. `DB_CYC` is 25 us of clock, which is 6250 cycles at 250 MHz.
- R4: A valid sample that returns `pg_raw` to the debounced level before the interval expires cancels the pending change. A later change then waits a full `DB_CYC` again.
- R5: `pg_drive_n` is 0 (pin pulled low) while the debounced level is not good, and 1 (pin released) while it is good.
- R6: With `OV_ALT`=0, `ov_flag` sets on a valid sample strictly above 107% (above 2140). A sample of exactly 2140 does not set it.
- R7: With `OV_ALT`=0, `ov_flag` clears on a valid sample below 104% (below 2080). Samples from 2080 to 2140 hold it.
- R8: With `OV_ALT`=1, the overvoltage pair is 105% set (above 2100) and 103% clear (below 2060).
- R9: While `en` is low or `rst_n` is low, `pg_raw`, `ov_flag` and `pg_drive_n` are 0 and the debounce count is cleared. After re-enable, power-good needs a full `DB_CYC` again.
- R10: Cycles with `fb_valid` low change neither comparator, whatever `fb_code` holds.
- R11: `ov_flag` is not debounced. It changes on the clock edge that captures the qualifying sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Monitor enable; low forces the idle state |
| fb_valid | input | 1 | Qualifies `fb_code` for one cycle |
| fb_code | input | FB_W | Unsigned feedback code, `TARGET_CODE` = regulation point |
| pg_drive_n | output | 1 | Open-drain control: 0 pulls the power-good pin low, 1 releases it |
| pg_raw | output | 1 | Undebounced hysteresis power-good level |
| ov_flag | output | 1 | Overvoltage indication |

## Verification
The bound checker checks the per-sample behaviour on every cycle. This covers the set and clear decisions of both comparators, the holding behaviour when no sample is valid, and the forced idle state while disabled. It also uses its own run-length counter to confirm that the debounced level never moves before `pg_raw` has disagreed with it for the full interval, and that it does move at the end of that interval. Only the directed scenarios show the exact threshold boundaries against literal codes, the restart after a reversing sample, the alternate overvoltage pair on a second instance, and the re-qualification after the monitor is re-enabled.

// File: rtl/pg_ov_pkg.sv
package pg_ov_pkg;

  // Threshold code = target * per-mille / 1000, evaluated at elaboration.
  function automatic int unsigned thr_code(input int unsigned target,
                                           input int unsigned permil);
    return (target * permil) / 1000;
  endfunction

  // Debounce length in clock cycles from a kHz clock rate and a time in us.
  function automatic int unsigned db_cycles(input int unsigned clk_khz,
                                            input int unsigned time_us);
    return (clk_khz * time_us) / 1000;
  endfunction

  // Per-mille threshold values.
  localparam int unsigned PG_RISE_PM   = 950;
  localparam int unsigned PG_FALL_PM   = 925;
  localparam int unsigned OV_SET_PM    = 1070;
  localparam int unsigned OV_CLR_PM    = 1040;
  localparam int unsigned OV_SET_PM_B  = 1050;
  localparam int unsigned OV_CLR_PM_B  = 1030;

endpackage

// File: rtl/pg_hyst_cmp.sv
module pg_hyst_cmp #(
  parameter int unsigned W        = 12,
  parameter int unsigned SET_CODE = 1900,
  parameter int unsigned CLR_CODE = 1850,
  parameter bit          SET_INCL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         valid,
  input  logic [W-1:0] code,
  output logic         state
);
  localparam logic [W-1:0] SET_C = W'(SET_CODE);
  localparam logic [W-1:0] CLR_C = W'(CLR_CODE);

  logic set_hit;
  logic clr_hit;

  generate
    if (SET_INCL) begin : g_set_ge
      assign set_hit = (code >= SET_C);
    end else begin : g_set_gt
      assign set_hit = (code > SET_C);
    end
  endgenerate

  assign clr_hit = (code < CLR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
    end else if (!en) begin
      state <= 1'b0;
    end else if (valid) begin
      if (set_hit)      state <= 1'b1;
      else if (clr_hit) state <= 1'b0;
    end
  end
endmodule

// File: rtl/pg_debounce.sv
module pg_debounce #(
  parameter int unsigned DB_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw,
  output logic level
);
  localparam int unsigned CW = (DB_CYC > 2) ? $clog2(DB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (raw != level) begin
      if (cnt == LAST) begin
        level <= raw;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/pg_ov_monitor.sv
module pg_ov_monitor
  import pg_ov_pkg::*;
#(
  parameter int unsigned FB_W        = 12,
  parameter int unsigned TARGET_CODE = 2000,
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned DEB_US      = 25,
  parameter bit          OV_ALT      = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            fb_valid,
  input  logic [FB_W-1:0] fb_code,
  output logic            pg_drive_n,
  output logic            pg_raw,
  output logic            ov_flag
);
  localparam int unsigned PG_SET = thr_code(TARGET_CODE, PG_RISE_PM);
  localparam int unsigned PG_CLR = thr_code(TARGET_CODE, PG_FALL_PM);
  localparam int unsigned OV_SET = thr_code(TARGET_CODE, OV_ALT ? OV_SET_PM_B : OV_SET_PM);
  localparam int unsigned OV_CLR = thr_code(TARGET_CODE, OV_ALT ? OV_CLR_PM_B : OV_CLR_PM);
  localparam int unsigned DB_CYC = db_cycles(CLK_KHZ, DEB_US);

  // Debounced power-good level, brought out for the checker.
  logic pg_good;

  pg_hyst_cmp #(
    .W(FB_W), .SET_CODE(PG_SET), .CLR_CODE(PG_CLR), .SET_INCL(1'b1)
  ) pg_cmp_i (
    .clk(clk), .rst_n(rst_n), .en(en), .valid(fb_valid),
    .code(fb_code), .state(pg_raw)
  );

  pg_debounce #(.DB_CYC(DB_CYC)) pg_db_i (
    .clk(clk), .rst_n(rst_n), .en(en), .raw(pg_raw), .level(pg_good)
  );

  pg_hyst_cmp #(
    .W(FB_W), .SET_CODE(OV_SET), .CLR_CODE(OV_CLR), .SET_INCL(1'b0)
  ) ov_cmp_i (
    .clk(clk), .rst_n(rst_n), .en(en), .valid(fb_valid),
    .code(fb_code), .state(ov_flag)
  );

  assign pg_drive_n = pg_good;
endmodule

// File: rtl/pg_ov_monitor_chk.sv
module pg_ov_monitor_chk
  import pg_ov_pkg::*;
#(
  parameter int unsigned FB_W        = 12,
  parameter int unsigned TARGET_CODE = 2000,
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned DEB_US      = 25,
  parameter bit          OV_ALT      = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            fb_valid,
  input logic [FB_W-1:0] fb_code,
  input logic            pg_drive_n,
  input logic            pg_raw,
  input logic            ov_flag,
  input logic            pg_good
);
  localparam int unsigned S_PG = thr_code(TARGET_CODE, PG_RISE_PM);
  localparam int unsigned C_PG = thr_code(TARGET_CODE, PG_FALL_PM);
  localparam int unsigned S_OV = thr_code(TARGET_CODE, OV_ALT ? OV_SET_PM_B : OV_SET_PM);
  localparam int unsigned C_OV = thr_code(TARGET_CODE, OV_ALT ? OV_CLR_PM_B : OV_CLR_PM);
  localparam int unsigned NDB  = db_cycles(CLK_KHZ, DEB_US);

  // Consecutive cycles of disagreement between raw and debounced level.
  int unsigned run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run <= 0;
    else if (en && (pg_raw != pg_good)) run <= (run == NDB - 1) ? 0 : run + 1;
    else                              run <= 0;
  end

  a_r1_pg_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_valid && (int'(fb_code) >= S_PG)) |=> pg_raw);
  a_r2_pg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_valid && (int'(fb_code) < C_PG)) |=> !pg_raw);
  a_r6_ov_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_valid && (int'(fb_code) > S_OV)) |=> ov_flag);
  a_r7_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_valid && (int'(fb_code) < C_OV)) |=> !ov_flag);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pg_raw && !ov_flag && !pg_drive_n));
  a_r10_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fb_valid) |=> ($stable(pg_raw) && $stable(ov_flag)));
  a_r3_early_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pg_raw != pg_good) && (run != NDB - 1)) |=> $stable(pg_good));
  a_r3_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pg_raw != pg_good) && (run == NDB - 1)) |=> (pg_good == $past(pg_raw)));
  a_r5_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pg_raw == pg_good)) |=> $stable(pg_drive_n));
endmodule

bind pg_ov_monitor pg_ov_monitor_chk #(
  .FB_W(FB_W), .TARGET_CODE(TARGET_CODE), .CLK_KHZ(CLK_KHZ),
  .DEB_US(DEB_US), .OV_ALT(OV_ALT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_valid(fb_valid), .fb_code(fb_code),
  .pg_drive_n(pg_drive_n), .pg_raw(pg_raw), .ov_flag(ov_flag), .pg_good(pg_good)
);

// File: tb/pg_ov_monitor_tb_top.sv
`timescale 1ns/1ps
module pg_ov_monitor_tb_top;
  localparam int DB = 25000 / 4;  // 25 us at a 4 ns period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fb_valid = 1'b0;
  logic [11:0] fb_code = '0;
  logic pg_drive_n, pg_raw, ov_flag;
  logic pg_drive_n_b, pg_raw_b, ov_flag_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pg_ov_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_valid(fb_valid), .fb_code(fb_code),
    .pg_drive_n(pg_drive_n), .pg_raw(pg_raw), .ov_flag(ov_flag)
  );

  pg_ov_monitor #(.OV_ALT(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_valid(fb_valid), .fb_code(fb_code),
    .pg_drive_n(pg_drive_n_b), .pg_raw(pg_raw_b), .ov_flag(ov_flag_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One valid sample; returns at the negedge after the capturing edge.
  task automatic send(input int code);
    fb_code  = 12'(code);
    fb_valid = 1'b1;
    @(negedge clk);
    fb_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset pg_drive_n", pg_drive_n, 0);
    chk("R9 reset pg_raw", pg_raw, 0);
    chk("R9 reset ov_flag", ov_flag, 0);
  endtask

  task automatic t_rise();
    send(1899);
    chk("R1 code 1899 keeps raw low", pg_raw, 0);
    send(1900);
    chk("R1 code 1900 sets raw", pg_raw, 1);
    cyc(DB - 1);
    chk("R3 pin still low one cycle early", pg_drive_n, 0);
    cyc(1);
    chk("R3 R5 pin released after interval", pg_drive_n, 1);
  endtask

  task automatic t_fall();
    send(1850);
    chk("R2 code 1850 holds raw", pg_raw, 1);
    send(1875);
    chk("R2 code 1875 holds raw", pg_raw, 1);
    send(1849);
    chk("R2 code 1849 clears raw", pg_raw, 0);
    cyc(DB - 1);
    chk("R3 pin still released one cycle early", pg_drive_n, 1);
    cyc(1);
    chk("R3 R5 pin pulled low after interval", pg_drive_n, 0);
  endtask

  task automatic t_glitch();
    send(1950);
    cyc(100);
    send(1800);
    cyc(DB + 10);
    chk("R4 short excursion ignored", pg_drive_n, 0);
    send(1950);
    cyc(3000);
    send(1800);
    send(1950);
    cyc(DB - 1);
    chk("R4 interval restarted after reversal", pg_drive_n, 0);
    cyc(1);
    chk("R4 pin released full interval after restart", pg_drive_n, 1);
  endtask

  task automatic t_no_valid();
    fb_code = 12'd0;
    cyc(50);
    chk("R10 raw unchanged without valid", pg_raw, 1);
    chk("R10 pin unchanged without valid", pg_drive_n, 1);
    fb_code = 12'd4000;
    cyc(50);
    chk("R10 ov unchanged without valid", ov_flag, 0);
  endtask

  task automatic t_ov();
    send(2100);
    chk("R8 alt 2100 does not set", ov_flag_b, 0);
    send(2101);
    chk("R8 alt 2101 sets", ov_flag_b, 1);
    chk("R6 main 2101 does not set", ov_flag, 0);
    send(2140);
    chk("R6 main 2140 does not set", ov_flag, 0);
    send(2141);
    chk("R6 R11 main 2141 sets on capture edge", ov_flag, 1);
    send(2080);
    chk("R7 main 2080 holds", ov_flag, 1);
    send(2079);
    chk("R7 main 2079 clears", ov_flag, 0);
    chk("R8 alt 2079 holds", ov_flag_b, 1);
    send(2060);
    chk("R8 alt 2060 holds", ov_flag_b, 1);
    send(2059);
    chk("R8 alt 2059 clears", ov_flag_b, 0);
    chk("R6 power-good unaffected", pg_drive_n, 1);
  endtask

  task automatic t_enable();
    send(2200);
    chk("R11 ov set before disable", ov_flag, 1);
    en = 1'b0;
    cyc(1);
    chk("R9 disable clears ov", ov_flag, 0);
    chk("R9 disable clears raw", pg_raw, 0);
    chk("R9 disable pulls pin low", pg_drive_n, 0);
    en = 1'b1;
    send(1950);
    chk("R9 raw sets after re-enable", pg_raw, 1);
    cyc(DB - 1);
    chk("R9 pin waits full interval after re-enable", pg_drive_n, 0);
    cyc(1);
    chk("R9 pin released after re-enable interval", pg_drive_n, 1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    en = 1'b1;
    cyc(2);
    t_rise();
    t_fall();
    t_glitch();
    t_no_valid();
    t_ov();
    t_enable();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule